// File: doc/BRIEF.md
# Triggered Pipeline Waveform Peak Finder

This block accepts a continuous stream of digitized calorimeter samples, one per asserted sample enable, and delays them in a pipeline. The pipeline is as long as the first-level trigger latency, 48 samples by default. A late trigger accept then starts a scan over a fixed window of the delayed samples, 30 by default. The scan finds the largest sample in the window and records where it sits. The peak and its 5-bit window position are written into a 16-entry show-ahead FIFO, which a simple bus-side read port drains.

The scan is a three-state machine. In **IDLE** it waits; a trigger takes the **accept** transition to **SCAN**. When the last window sample has been compared, the **finish** transition leads to **STORE**. The **commit** transition from STORE back to IDLE writes the result into the buffer. A trigger that arrives in SCAN or STORE is not queued. It is rejected, counted, and latched into a sticky busy-error flag. A result that meets a full buffer is dropped and counted as an overflow.

Top module: `trig_peak_finder`

## Requirements
- R1: After reset the buffer is empty and not full, the scan is idle, and the busy-error flag and both counters read zero.
- R2: Window position 0 is the sample that entered the pipeline exactly DEPTH enabled samples before the first enabled cycle at or after an accepted trigger. A trigger together with an enable uses that same cycle.
- R3: The window covers exactly WIN consecutive enabled samples. Samples just before or just after it never affect the result.
- R4: Each buffer entry holds the largest window sample and its position, counted from 0 up to WIN-1.
- R5: When several samples share the maximum, the position of the earliest one is reported.
- R6: Samples are compared as unsigned 15-bit values, so both 10-bit raw values and range-extended values up to 32767 are handled.
- R7: Cycles with the sample enable low neither advance the pipeline nor advance the scan.
- R8: A trigger that arrives while the machine is in SCAN or STORE adds no entry. It increments the reject counter and sets the busy-error flag, which stays set until reset.
- R9: The buffer holds 16 entries in arrival order. The head entry is visible while the buffer is not empty, and a read enable removes it.
- R10: A result that finds the buffer full is dropped, the buffer contents are left unchanged, and the overflow counter increments.
- R11: The scan-busy output is high from the cycle after an accepted trigger until the result has been committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Sample enable, one pulse per sample |
| smp_in | input | 15 | Unsigned sample value |
| trig | input | 1 | Trigger accept pulse |
| rd_en | input | 1 | Removes the head buffer entry |
| rd_empty | output | 1 | Buffer empty |
| rd_full | output | 1 | Buffer full |
| rd_peak | output | 15 | Peak value of the head entry |
| rd_pos | output | 5 | Window position of the head entry |
| scan_busy | output | 1 | Machine is not in IDLE |
| busy_err | output | 1 | Sticky flag for a rejected trigger |
| rej_cnt | output | 8 | Count of rejected triggers, saturating |
| ovf_cnt | output | 8 | Count of dropped results, saturating |

## Verification
The hardest conditions to reach are the overflow drop and the exact window alignment. Overflow needs sixteen complete scans that nobody reads out, followed by a seventeenth. The bench queues seventeen triggered streams without a single read, then drains the buffer to confirm that the first entry survived and that only sixteen entries are present. Alignment is tested with patterns that put larger values just outside both window edges, including a ramp and a descending slope. A pipeline or window that is off by one sample then reports a different peak.

// File: rtl/pkf_pkg.sv
package pkf_pkg;
    localparam int SAMPLE_W = 15;
    localparam int POS_W    = 5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_STORE = 2'd2
    } scan_state_t;

    typedef struct packed {
        logic [SAMPLE_W-1:0] peak;
        logic [POS_W-1:0]    pos;
    } peak_entry_t;
endpackage

// File: rtl/pkf_delay_line.sv
module pkf_delay_line #(
    parameter int W     = 15,
    parameter int DEPTH = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] ptr;

    assign dout = mem[ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (en) begin
            mem[ptr] <= din;
            ptr      <= (ptr == AW'(DEPTH-1)) ? '0 : ptr + 1'b1;
        end
    end

    // R7: the read pointer only moves on an enabled sample
    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(ptr));
endmodule

// File: rtl/pkf_scanner.sv
module pkf_scanner
    import pkf_pkg::*;
#(
    parameter int WIN   = 30,
    parameter int CNT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                trig,
    input  logic [SAMPLE_W-1:0] dly,
    output logic                push,
    output peak_entry_t         result,
    output logic                busy,
    output logic                busy_err,
    output logic [CNT_W-1:0]    rej_cnt
);
    localparam int CW = $clog2(WIN + 1);

    scan_state_t         st, nxt;
    logic [CW-1:0]       cnt;
    logic [SAMPLE_W-1:0] best;
    logic [POS_W-1:0]    best_pos;
    logic                take, first, reject;
    logic [CW-1:0]       idx;

    assign take   = en && (st == ST_SCAN || (st == ST_IDLE && trig));
    assign first  = (st == ST_IDLE) || (cnt == '0);
    assign idx    = (st == ST_IDLE) ? '0 : cnt;
    assign reject = trig && (st != ST_IDLE);

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:  if (trig) nxt = ST_SCAN;
            ST_SCAN:  if (take && cnt == CW'(WIN-1)) nxt = ST_STORE;
            ST_STORE: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            best     <= '0;
            best_pos <= '0;
            busy_err <= 1'b0;
            rej_cnt  <= '0;
        end else begin
            if (take) begin
                if (first || dly > best) begin
                    best     <= dly;
                    best_pos <= POS_W'(idx);
                end
                cnt <= idx + 1'b1;
            end else if (st == ST_IDLE && trig) begin
                cnt <= '0;
            end
            if (reject) begin
                busy_err <= 1'b1;
                if (rej_cnt != '1) rej_cnt <= rej_cnt + 1'b1;
            end
        end
    end

    assign push        = (st == ST_STORE);
    assign busy        = (st != ST_IDLE);
    assign result.peak = best;
    assign result.pos  = best_pos;

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(WIN));
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_err |=> busy_err);
    p_reject_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && busy) |=> busy_err);
    p_commit_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !push && !busy);
endmodule

// File: rtl/pkf_fifo.sv
module pkf_fifo
    import pkf_pkg::*;
#(
    parameter int FDEPTH = 16,
    parameter int CNT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  peak_entry_t      wdata,
    input  logic             pop,
    output peak_entry_t      rdata,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] ovf_cnt
);
    localparam int AW = $clog2(FDEPTH);

    peak_entry_t   mem [FDEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   level;
    logic          do_push, do_pop;

    assign empty   = (level == '0);
    assign full    = (level == (AW+1)'(FDEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp      <= '0;
            rp      <= '0;
            level   <= '0;
            ovf_cnt <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= wdata;
                wp      <= (wp == AW'(FDEPTH-1)) ? '0 : wp + 1'b1;
            end
            if (do_pop) rp <= (rp == AW'(FDEPTH-1)) ? '0 : rp + 1'b1;
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (!do_push && do_pop) level <= level - 1'b1;
            if (push && full && ovf_cnt != '1) ovf_cnt <= ovf_cnt + 1'b1;
        end
    end

    p_level_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        level <= (AW+1)'(FDEPTH));
    p_drop_keeps_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> full && $stable(wp));
endmodule

// File: rtl/trig_peak_finder.sv
module trig_peak_finder
    import pkf_pkg::*;
#(
    parameter int DEPTH  = 48,
    parameter int WIN    = 30,
    parameter int FDEPTH = 16,
    parameter int CNT_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_en,
    input  logic [SAMPLE_W-1:0] smp_in,
    input  logic                trig,
    input  logic                rd_en,
    output logic                rd_empty,
    output logic                rd_full,
    output logic [SAMPLE_W-1:0] rd_peak,
    output logic [POS_W-1:0]    rd_pos,
    output logic                scan_busy,
    output logic                busy_err,
    output logic [CNT_W-1:0]    rej_cnt,
    output logic [CNT_W-1:0]    ovf_cnt
);
    logic [SAMPLE_W-1:0] dly;
    logic                push;
    peak_entry_t         res, head;

    pkf_delay_line #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_dly (
        .clk(clk), .rst_n(rst_n), .en(smp_en), .din(smp_in), .dout(dly)
    );

    pkf_scanner #(.WIN(WIN), .CNT_W(CNT_W)) u_scan (
        .clk(clk), .rst_n(rst_n), .en(smp_en), .trig(trig), .dly(dly),
        .push(push), .result(res), .busy(scan_busy),
        .busy_err(busy_err), .rej_cnt(rej_cnt)
    );

    pkf_fifo #(.FDEPTH(FDEPTH), .CNT_W(CNT_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .wdata(res), .pop(rd_en),
        .rdata(head), .empty(rd_empty), .full(rd_full), .ovf_cnt(ovf_cnt)
    );

    assign rd_peak = head.peak;
    assign rd_pos  = head.pos;

    p_pos_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_empty |-> rd_pos < POS_W'(WIN));
endmodule

// File: tb/trig_peak_finder_test.sv
module trig_peak_finder_test;
    localparam int DEPTH = 48;
    localparam int WIN   = 30;
    localparam int PRE   = 60;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        smp_en = 0;
    logic [14:0] smp_in = 0;
    logic        trig = 0;
    logic        rd_en = 0;
    logic        rd_empty, rd_full, scan_busy, busy_err;
    logic [14:0] rd_peak;
    logic [4:0]  rd_pos;
    logic [7:0]  rej_cnt, ovf_cnt;

    int checks = 0;
    int errors = 0;
    int n_en   = 0;

    always #5 clk = ~clk;

    trig_peak_finder uut (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .smp_in(smp_in),
        .trig(trig), .rd_en(rd_en), .rd_empty(rd_empty), .rd_full(rd_full),
        .rd_peak(rd_peak), .rd_pos(rd_pos), .scan_busy(scan_busy),
        .busy_err(busy_err), .rej_cnt(rej_cnt), .ovf_cnt(ovf_cnt)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // sample value by offset from window position 0
    function automatic int pat(input int mode, input int off);
        case (mode)
            0: return (off < 0) ? 0 : off + 1;
            1: return (off == 7) ? 1000 : (off == -1 || off == WIN) ? 2000 : 5 + (off & 3);
            2: return (off == 3 || off == 20) ? 700 : 100;
            3: return (off == 12) ? 32767 : (off == 13) ? 1023 : 0;
            default: return 500 - off;
        endcase
    endfunction

    task automatic drive(input bit en, input int v, input bit t);
        @(negedge clk);
        smp_en = en; smp_in = 15'(v); trig = t;
        @(posedge clk);
        if (en) n_en++;
    endtask

    task automatic stream(input int mode, input int gap, input int extra);
        int s;
        s = n_en + PRE - DEPTH;
        for (int i = 0; i < PRE + WIN + 4; i++) begin
            for (int g = 1; g < gap; g++) drive(0, 0, 0);
            drive(1, pat(mode, n_en - s), (i == PRE) || (i == extra));
            if (i == PRE + 5) begin
                #1 chk("R11 busy during scan", int'(scan_busy), 1);
            end
        end
        @(negedge clk);
        smp_en = 0; trig = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_head(input string req, input int mode);
        int m, p;
        m = -1; p = 0;
        for (int o = 0; o < WIN; o++)
            if (pat(mode, o) > m) begin m = pat(mode, o); p = o; end
        chk({req, " not empty"}, int'(rd_empty), 0);
        chk({req, " peak"}, int'(rd_peak), m);
        chk({req, " pos"}, int'(rd_pos), p);
    endtask

    task automatic pop1;
        @(negedge clk); rd_en = 1;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic t_reset;
        chk("R1 empty", int'(rd_empty), 1);
        chk("R1 full", int'(rd_full), 0);
        chk("R1 busy", int'(scan_busy), 0);
        chk("R1 err", int'(busy_err), 0);
        chk("R1 rej", int'(rej_cnt), 0);
        chk("R1 ovf", int'(ovf_cnt), 0);
    endtask

    task automatic t_single(input string req, input int mode, input int gap);
        stream(mode, gap, -1);
        chk({req, " idle after commit R11"}, int'(scan_busy), 0);
        expect_head(req, mode);
        pop1();
        chk({req, " one entry R9"}, int'(rd_empty), 1);
    endtask

    task automatic t_busy;
        stream(4, 1, PRE + 10);
        chk("R8 err set", int'(busy_err), 1);
        chk("R8 rej count", int'(rej_cnt), 1);
        expect_head("R8 first kept", 4);
        pop1();
        chk("R8 no extra entry", int'(rd_empty), 1);
        stream(2, 1, -1);
        chk("R8 err sticky", int'(busy_err), 1);
        pop1();
    endtask

    task automatic t_overflow;
        stream(0, 1, -1);
        for (int k = 1; k < 16; k++) stream(4, 1, -1);
        chk("R9 full at 16", int'(rd_full), 1);
        chk("R10 no ovf yet", int'(ovf_cnt), 0);
        stream(3, 1, -1);
        chk("R10 ovf count", int'(ovf_cnt), 1);
        chk("R10 still full", int'(rd_full), 1);
        expect_head("R9 order head", 0);
        pop1();
        expect_head("R9 order second", 4);
        for (int k = 1; k < 16; k++) pop1();
        chk("R10 dropped entry absent", int'(rd_empty), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_single("R2 R3 ramp", 0, 1);
        t_single("R3 spike edges", 1, 1);
        t_single("R5 tie", 2, 1);
        t_single("R6 wide", 3, 1);
        t_single("R2 start slope", 4, 1);
        t_single("R7 gapped", 1, 4);
        t_single("R4 gapped ramp R7", 0, 3);
        t_busy();
        t_overflow();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule